// File: doc/BRIEF.md
# Exception Entry and Return Unit

This unit sits beside the issue stage of a small 32-bit embedded core. It decides each cycle whether to enter an exception. An enabled external interrupt is one source. A misaligned or badly placed storage operation is the other. When the core leaves a handler, the unit carries out the return. On entry it copies a return address and the current machine state into two save/restore registers. On an alignment fault it also records the faulting effective address. It then reduces the machine state to its protected form and redirects fetch to a vector. The vector is the 16-bit prefix register in the upper half joined with a fixed low offset for each cause.

A return strobe copies the saved state back and redirects fetch to the saved address. Two simple write ports load the machine state register and the vector prefix. The unit has no pipeline of its own. A fault is detected in the same cycle as the instruction, so the kill output blocks that instruction from completing. The redirect, the new PC and all register updates appear after the next clock edge.

Top module: `exc_unit`

## Requirements
- R1: An external interrupt (`ext_irq` high) is taken only when the external-enable bit of the machine state (`msr_o[6]`) is 1, no alignment fault is present and no return is requested in the same cycle. Otherwise it has no effect, and a held request is taken in a later cycle once these conditions hold.
- R2: When an external interrupt is taken, after the next edge `srr0_o` holds the `next_pc` of that cycle and `srr1_o` holds the machine state from before entry.
- R3: On any exception entry, the following bits of `msr_o` become 0: wait-enable (bit 8), external-enable (bit 6), problem-state (bit 5), auxiliary enable (bit 4), instruction relocate (bit 2) and data relocate (bit 1).
- R4: On any exception entry, critical-enable (bit 7), machine-check-enable (bit 3) and debug-enable (bit 0) keep their values.
- R5: The cycle after an entry, `redirect` is high for exactly one cycle. `redirect_pc` is the prefix register in bits 31:16 joined with 0x0500 for an external interrupt or 0x0600 for an alignment fault.
- R6: A valid data-cache-block-zero instruction (class 1) raises an alignment fault when `attr_nocache` or `attr_wthru` is high. With both low it raises none.
- R7: A valid data-cache-read (class 2), load-and-reserve (class 3) or store-conditional (class 4) raises an alignment fault when `eff_addr[1:0]` is nonzero. Other classes never fault on address alignment.
- R8: An alignment fault drives `kill` high in the same cycle. After the edge, `srr0_o` holds `instr_pc`, `srr1_o` holds the prior machine state and `fault_addr_o` holds `eff_addr`.
- R9: A return (`rfi` high, no alignment fault) copies `srr1_o` into `msr_o`. It pulses `redirect` with `redirect_pc` equal to `srr0_o`.
- R10: When an alignment fault and an external interrupt arrive in the same cycle, the alignment fault is taken. The interrupt stays pending and is taken later only if external-enable is set again.
- R11: `fault_addr_o` changes only on alignment faults.
- R12: Synchronous reset clears `msr_o`, `srr0_o`, `srr1_o`, `fault_addr_o`, the prefix and `redirect`.
- R13: `msr_we` loads `msr_wdata` into `msr_o` when no exception or return occurs in that cycle. `pfx_we` loads `pfx_wdata` into the prefix, and the new prefix is used for entries from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction at issue is valid |
| instr_class | input | 3 | Instruction class code (0 other, 1 block zero, 2 cache read, 3 load-reserve, 4 store-conditional) |
| instr_pc | input | 32 | Address of the issuing instruction |
| next_pc | input | 32 | Address of the next sequential instruction |
| eff_addr | input | 32 | Effective data address of the instruction |
| attr_nocache | input | 1 | Target storage is non-cacheable |
| attr_wthru | input | 1 | Target storage is write-through |
| ext_irq | input | 1 | Level external interrupt request |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_we | input | 1 | Machine state write enable |
| msr_wdata | input | 9 | Machine state write value |
| pfx_we | input | 1 | Vector prefix write enable |
| pfx_wdata | input | 16 | Vector prefix write value (upper address half) |
| kill | output | 1 | Current instruction must not complete |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | New fetch address |
| msr_o | output | 9 | Machine state register |
| srr0_o | output | 32 | Save/restore register 0 (return address) |
| srr1_o | output | 9 | Save/restore register 1 (saved machine state) |
| fault_addr_o | output | 32 | Faulting effective address |

## Verification
The assertions assume that `rfi` and the instruction fields describe at most one event per cycle. They also assume that `ext_irq`, as a level, stays high until it is serviced. The property that ties a return to the saved state assumes that nothing else writes the save/restore registers in that same cycle. The bench drives every input on the falling edge, one event per step. It holds the interrupt request across the cycles where it is masked or outranked. It writes the machine state only in cycles without an entry or return, except where R13 is checked on purpose.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef struct packed {
        logic wt;   // wait enable
        logic ce;   // critical enable
        logic ee;   // external enable
        logic pr;   // problem state
        logic ae;   // auxiliary enable
        logic me;   // machine-check enable
        logic ir;   // instruction relocate
        logic dr;   // data relocate
        logic de;   // debug enable
    } msr_t;

    localparam int MSR_W = $bits(msr_t);

    typedef enum logic [2:0] {
        IC_OTHER  = 3'd0,
        IC_BLKZ   = 3'd1,
        IC_CRD    = 3'd2,
        IC_LDRSV  = 3'd3,
        IC_STCOND = 3'd4
    } iclass_e;

    typedef enum logic [2:0] {
        CS_NONE,
        CS_ALIGN,
        CS_RFI,
        CS_EXT,
        CS_MSRW
    } cause_e;

    localparam int          VEC_LO_W  = 16;
    localparam logic [15:0] OFS_EXT   = 16'h0500;
    localparam logic [15:0] OFS_ALIGN = 16'h0600;

    function automatic msr_t msr_on_entry(input msr_t m);
        msr_t r;
        r    = '0;
        r.ce = m.ce;
        r.me = m.me;
        r.de = m.de;
        return r;
    endfunction

    function automatic logic needs_word(input iclass_e c);
        return (c == IC_CRD) || (c == IC_LDRSV) || (c == IC_STCOND);
    endfunction

endpackage

// File: rtl/exc_align_detect.sv
module exc_align_detect
    import exc_pkg::*;
(
    input  logic       valid,
    input  iclass_e    cls,
    input  logic [1:0] ea_lo,
    input  logic       nocache,
    input  logic       wthru,
    output logic       fault
);
    logic blkz_bad;
    logic word_bad;

    always_comb begin
        blkz_bad = (cls == IC_BLKZ) && (nocache || wthru);
        word_bad = needs_word(cls) && (ea_lo != 2'b00);
        fault    = valid && (blkz_bad || word_bad);
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   align_fault,
    input  logic   rfi,
    input  logic   ext_irq,
    input  logic   ee,
    input  logic   msr_we,
    output cause_e cause
);
    always_comb begin
        if (align_fault)          cause = CS_ALIGN;
        else if (rfi)             cause = CS_RFI;
        else if (ext_irq && ee)   cause = CS_EXT;
        else if (msr_we)          cause = CS_MSRW;
        else                      cause = CS_NONE;
    end
endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int PFX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cause_e           cause,
    input  logic [XLEN-1:0]  instr_pc,
    input  logic [XLEN-1:0]  next_pc,
    input  logic [XLEN-1:0]  eff_addr,
    input  msr_t             msr_wdata,
    input  logic             pfx_we,
    input  logic [PFX_W-1:0] pfx_wdata,
    output msr_t             msr_q,
    output logic [XLEN-1:0]  srr0_q,
    output msr_t             srr1_q,
    output logic [XLEN-1:0]  fa_q,
    output logic             redirect_q,
    output logic [XLEN-1:0]  redirect_pc_q
);
    localparam int LO_W = XLEN - PFX_W;

    logic [PFX_W-1:0] pfx_q;
    logic             entering;

    assign entering = (cause == CS_ALIGN) || (cause == CS_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q         <= '0;
            srr0_q        <= '0;
            srr1_q        <= '0;
            fa_q          <= '0;
            pfx_q         <= '0;
            redirect_q    <= 1'b0;
            redirect_pc_q <= '0;
        end else begin
            redirect_q <= 1'b0;
            if (pfx_we) pfx_q <= pfx_wdata;
            unique case (cause)
                CS_ALIGN: begin
                    srr0_q        <= instr_pc;
                    srr1_q        <= msr_q;
                    fa_q          <= eff_addr;
                    msr_q         <= msr_on_entry(msr_q);
                    redirect_q    <= 1'b1;
                    redirect_pc_q <= {pfx_q, OFS_ALIGN[LO_W-1:0]};
                end
                CS_EXT: begin
                    srr0_q        <= next_pc;
                    srr1_q        <= msr_q;
                    msr_q         <= msr_on_entry(msr_q);
                    redirect_q    <= 1'b1;
                    redirect_pc_q <= {pfx_q, OFS_EXT[LO_W-1:0]};
                end
                CS_RFI: begin
                    msr_q         <= srr1_q;
                    redirect_q    <= 1'b1;
                    redirect_pc_q <= srr0_q;
                end
                CS_MSRW: msr_q <= msr_wdata;
                default: ;
            endcase
        end
    end

    // R3
    entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        entering |=> (!msr_q.wt && !msr_q.ee && !msr_q.pr && !msr_q.ae && !msr_q.ir && !msr_q.dr));

    // R4
    entry_keep_chk: assert property (@(posedge clk) disable iff (rst)
        entering |=> (msr_q.ce == $past(msr_q.ce) && msr_q.me == $past(msr_q.me) && msr_q.de == $past(msr_q.de)));

    // R5
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_q |=> (!redirect_q || $past(cause) != CS_NONE));

    // R8
    align_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == CS_ALIGN) |=> (redirect_q && redirect_pc_q[LO_W-1:0] == OFS_ALIGN[LO_W-1:0] && fa_q == $past(eff_addr)));

    // R9
    rfi_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == CS_RFI) |=> (msr_q == $past(srr1_q) && redirect_pc_q == $past(srr0_q) && redirect_q));

    // R11
    fa_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cause != CS_ALIGN) |=> $stable(fa_q));
endmodule

// File: rtl/exc_unit.sv
module exc_unit
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     instr_valid,
    input  logic [2:0]               instr_class,
    input  logic [XLEN-1:0]          instr_pc,
    input  logic [XLEN-1:0]          next_pc,
    input  logic [XLEN-1:0]          eff_addr,
    input  logic                     attr_nocache,
    input  logic                     attr_wthru,
    input  logic                     ext_irq,
    input  logic                     rfi,
    input  logic                     msr_we,
    input  logic [8:0]               msr_wdata,
    input  logic                     pfx_we,
    input  logic [XLEN-VEC_LO_W-1:0] pfx_wdata,
    output logic                     kill,
    output logic                     redirect,
    output logic [XLEN-1:0]          redirect_pc,
    output logic [8:0]               msr_o,
    output logic [XLEN-1:0]          srr0_o,
    output logic [8:0]               srr1_o,
    output logic [XLEN-1:0]          fault_addr_o
);
    localparam int PFX_W = XLEN - VEC_LO_W;

    logic   align_fault;
    cause_e cause;
    msr_t   msr_q;
    msr_t   srr1_q;

    exc_align_detect u_detect (
        .valid   (instr_valid),
        .cls     (iclass_e'(instr_class)),
        .ea_lo   (eff_addr[1:0]),
        .nocache (attr_nocache),
        .wthru   (attr_wthru),
        .fault   (align_fault)
    );

    exc_arbiter u_arb (
        .align_fault (align_fault),
        .rfi         (rfi),
        .ext_irq     (ext_irq),
        .ee          (msr_q.ee),
        .msr_we      (msr_we),
        .cause       (cause)
    );

    exc_state #(.XLEN(XLEN), .PFX_W(PFX_W)) u_state (
        .clk           (clk),
        .rst           (rst),
        .cause         (cause),
        .instr_pc      (instr_pc),
        .next_pc       (next_pc),
        .eff_addr      (eff_addr),
        .msr_wdata     (msr_t'(msr_wdata)),
        .pfx_we        (pfx_we),
        .pfx_wdata     (pfx_wdata),
        .msr_q         (msr_q),
        .srr0_q        (srr0_o),
        .srr1_q        (srr1_q),
        .fa_q          (fault_addr_o),
        .redirect_q    (redirect),
        .redirect_pc_q (redirect_pc)
    );

    assign kill   = align_fault;
    assign msr_o  = msr_q;
    assign srr1_o = srr1_q;

    // R1
    ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_irq && !msr_q.ee && !align_fault && !rfi) |=> !redirect);

    // R10
    align_first_chk: assert property (@(posedge clk) disable iff (rst)
        (align_fault && ext_irq) |=> (srr0_o == $past(instr_pc)));
endmodule

// File: tb/exc_unit_tb.sv
`timescale 1ns/1ps
module exc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [2:0]  instr_class;
    logic [31:0] instr_pc, next_pc, eff_addr;
    logic        attr_nocache, attr_wthru, ext_irq, rfi, msr_we, pfx_we;
    logic [8:0]  msr_wdata;
    logic [15:0] pfx_wdata;
    logic        kill, redirect;
    logic [31:0] redirect_pc, srr0_o, fault_addr_o;
    logic [8:0]  msr_o, srr1_o;

    always #10 clk = ~clk;

    exc_unit u_dut (.*);

    typedef struct {
        logic        redir;
        logic [31:0] pc;
        logic [8:0]  msr;
        logic [31:0] srr0;
        logic [8:0]  srr1;
        logic [31:0] fa;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [8:0]  m_msr, m_srr1;
    logic [31:0] m_srr0, m_fa;
    logic [15:0] m_pfx;

    localparam logic [8:0] KEEP = 9'h089;   // bits 7, 3, 0
    localparam int EE = 6;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] cls, input logic [31:0] ipc,
                        input logic [31:0] ea, input logic nc, input logic wt,
                        input logic irq, input logic rf, input logic mwe,
                        input logic [8:0] mwd, input logic pwe,
                        input logic [15:0] pwd, input string tag);
        exp_t e;
        logic flt;
        @(negedge clk);
        instr_valid = v; instr_class = cls; instr_pc = ipc; next_pc = ipc + 32'd4;
        eff_addr = ea; attr_nocache = nc; attr_wthru = wt; ext_irq = irq; rfi = rf;
        msr_we = mwe; msr_wdata = mwd; pfx_we = pwe; pfx_wdata = pwd;
        flt = v && (((cls == 3'd1) && (nc || wt)) ||
                    ((cls >= 3'd2 && cls <= 3'd4) && (ea[1:0] != 2'b00)));
        #1 chk({tag, " kill"}, {31'd0, kill}, {31'd0, flt});
        e.redir = 1'b0; e.pc = 32'hx;
        if (flt) begin
            m_srr0 = ipc; m_srr1 = m_msr; m_fa = ea; m_msr = m_msr & KEEP;
            e.redir = 1'b1; e.pc = {m_pfx, 16'h0600};
        end else if (rf) begin
            e.redir = 1'b1; e.pc = m_srr0; m_msr = m_srr1;
        end else if (irq && m_msr[EE]) begin
            m_srr0 = ipc + 32'd4; m_srr1 = m_msr; m_msr = m_msr & KEEP;
            e.redir = 1'b1; e.pc = {m_pfx, 16'h0500};
        end else if (mwe) begin
            m_msr = mwd;
        end
        if (pwe) m_pfx = pwd;
        e.msr = m_msr; e.srr0 = m_srr0; e.srr1 = m_srr1; e.fa = m_fa; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic irq, input string tag);
        step(0, 3'd0, 32'h0000_1000, 32'h0, 0, 0, irq, 0, 0, 9'h0, 0, 16'h0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk({e.tag, " redirect"}, {31'd0, redirect}, {31'd0, e.redir});
                if (e.redir) chk({e.tag, " pc"}, redirect_pc, e.pc);
                chk({e.tag, " msr"}, {23'd0, msr_o}, {23'd0, e.msr});
                chk({e.tag, " srr0"}, srr0_o, e.srr0);
                chk({e.tag, " srr1"}, {23'd0, srr1_o}, {23'd0, e.srr1});
                chk({e.tag, " fa"}, fault_addr_o, e.fa);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; instr_valid = 0; instr_class = 0; instr_pc = 0; next_pc = 0;
        eff_addr = 0; attr_nocache = 0; attr_wthru = 0; ext_irq = 0; rfi = 0;
        msr_we = 0; msr_wdata = 0; pfx_we = 0; pfx_wdata = 0;
        m_msr = 0; m_srr0 = 0; m_srr1 = 0; m_fa = 0; m_pfx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R12 reset state
        chk("R12 msr", {23'd0, msr_o}, 32'd0);
        chk("R12 srr0", srr0_o, 32'd0);
        chk("R12 srr1", {23'd0, srr1_o}, 32'd0);
        chk("R12 fa", fault_addr_o, 32'd0);
        chk("R12 redirect", {31'd0, redirect}, 32'd0);

        // R1 masked interrupt after reset has no effect
        idle(1, "R1 masked");
        idle(1, "R1 masked2");
        // R13 write ports
        step(0, 0, 32'h100, 0, 0, 0, 0, 0, 1, 9'h1FF, 1, 16'hABCD, "R13 write");
        // R1 R2 R3 R4 R5 external entry
        step(0, 0, 32'h2000, 0, 0, 0, 1, 0, 0, 9'h0, 0, 0, "R2 ext entry");
        idle(1, "R1 held after entry");
        // R9 return
        step(0, 0, 32'h3000, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi");
        // R1 interrupt while rfi: rfi wins, then taken next cycle
        step(0, 0, 32'h3100, 0, 0, 0, 1, 1, 0, 9'h0, 0, 0, "R1 rfi first");
        step(0, 0, 32'h3200, 0, 0, 0, 1, 0, 0, 9'h0, 0, 0, "R5 ext vector");
        step(0, 0, 32'h3300, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi2");
        // R6 block-zero cases
        step(1, 3'd1, 32'h4000, 32'h8000_0040, 1, 0, 0, 0, 0, 0, 0, 0, "R6 nocache");
        step(0, 0, 32'h4100, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi3");
        step(1, 3'd1, 32'h4200, 32'h8000_0080, 0, 1, 0, 0, 0, 0, 0, 0, "R6 wthru");
        step(0, 0, 32'h4300, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi4");
        step(1, 3'd1, 32'h4400, 32'h8000_00C3, 0, 0, 0, 0, 0, 0, 0, 0, "R6 cached ok");
        step(0, 3'd1, 32'h4500, 32'h8000_0000, 1, 1, 0, 0, 0, 0, 0, 0, "R6 not valid");
        // R7 word classes
        step(1, 3'd3, 32'h5000, 32'h0000_1002, 0, 0, 0, 0, 0, 0, 0, 0, "R7 ldrsv mis");
        step(0, 0, 32'h5100, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi5");
        step(1, 3'd4, 32'h5200, 32'h0000_2001, 0, 0, 0, 0, 0, 0, 0, 0, "R7 stcond mis");
        step(0, 0, 32'h5300, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi6");
        step(1, 3'd2, 32'h5400, 32'h0000_3003, 1, 1, 0, 0, 0, 0, 0, 0, "R7 crd mis");
        step(0, 0, 32'h5500, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi7");
        step(1, 3'd3, 32'h5600, 32'h0000_3004, 0, 0, 0, 0, 0, 0, 0, 0, "R7 aligned ok");
        step(1, 3'd0, 32'h5700, 32'h0000_3007, 1, 1, 0, 0, 0, 0, 0, 0, "R7 other class");
        // R11 fault address untouched by external entry
        step(0, 0, 32'h5800, 0, 0, 0, 1, 0, 0, 9'h0, 0, 0, "R11 ext keeps fa");
        step(0, 0, 32'h5900, 0, 0, 0, 0, 1, 0, 9'h0, 0, 0, "R9 rfi8");
        // R10 simultaneous align + external
        step(1, 3'd4, 32'h6000, 32'h0000_4002, 0, 0, 1, 0, 0, 0, 0, 0, "R10 align wins");
        idle(1, "R10 ext masked");
        step(0, 0, 32'h6100, 0, 0, 0, 1, 0, 1, 9'h1C0, 0, 0, "R10 msr set");
        idle(1, "R10 ext later");
        // R13 new prefix used from next cycle; msr write ignored on entry
        step(0, 0, 32'h6200, 0, 0, 0, 0, 0, 1, 9'h0C9, 1, 16'h1234, "R13 pfx");
        step(1, 3'd1, 32'h6300, 32'hC000_0000, 1, 0, 0, 0, 1, 9'h1FF, 0, 0, "R13 msr vs entry");
        idle(0, "R13 settle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule